// File: doc/BRIEF.md
# SCSI Host Adapter Register and Command Interface

This block is the processor-facing side of a small SCSI host adapter. Byte-wide registers sit on four-byte address spacing. Each register has two copies: a write-side copy that records every byte the processor stores, and a read-side copy that the processor sees. Writes and reads have side effects. A write to a transfer-count byte clears the terminal-count status flag. A write to the command register dispatches a command. A read of the interrupt register acknowledges the interrupt. The FIFO register gives access to a 32-entry byte buffer.

Commands go out to the phase sequencer as a one-cycle strobe that carries the opcode and a DMA flag. Three commands act inside the block: flush, chip reset and bus reset. A fourth opens a command-collection window, and during that window FIFO writes are counted as command bytes instead of being buffered. Another command closes the window. The sequencer reports status back through a set-bit input. The block drives a level interrupt request.

Top module: `scsiRegIf`

## Requirements
- R1: The register index is address bits [5:2]. Address bits [1:0] have no effect, so addresses 0x30 and 0x33 both select register 12.
- R2: After reset every register reads 0x00, except register 14, which reads 0x04. The interrupt, command strobe and command-byte count are all 0.
- R3: A write to register 0 or register 1 clears bit 4 (terminal count, mask 0x10) of the status register, register 4.
- R4: A command byte with bit 7 set copies the last written values of registers 0 and 1 into their readable copies. A command byte with bit 7 clear leaves the readable copies as they are.
- R5: One cycle after a write to register 3, cmdStrobe is high for exactly one cycle. cmdOpcode carries bits [6:0] of the written byte and cmdDma carries bit 7.
- R6: Opcode 0x01 (flush) sets register 5 to 0x08, sets register 6 to 0x00 and empties the data buffer.
- R7: Opcode 0x02 (chip reset) returns every register, the data buffer, the write-side copies, the command-byte count and irq to the state given in R2.
- R8: Opcode 0x03 (bus reset) sets register 5 to 0x80. It raises irq only when bit 6 of register 8 is clear.
- R9: A read of register 5 returns its contents, clears bits 7, 6 and 5 (mask 0xE0) of register 4 and drops irq.
- R10: A write to register 11 stores the byte ANDed with 0x15. Writes to registers 3, 8 and 12 to 15 store the byte as written. Writes to registers 4 to 7, 9 and 10 leave their readable copies unchanged.
- R11: Outside a command-collection window, FIFO writes (register 2) fill a 32-byte buffer and bytes past 32 are dropped. FIFO reads return the bytes in write order. A FIFO read with the buffer empty returns the last byte that was read out.
- R12: Opcode 0x43 clears the command-byte count and opens collection. While collection is open, FIFO writes raise cmdLen (up to 32) and do not reach the data buffer. Opcode 0x10 closes collection and leaves cmdLen unchanged.
- R13: A high bit of statusSet is ORed into register 4. statusSet bit 7 raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address of the access |
| wrEn | input | 1 | Write strobe; takes priority over rdEn |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, registered |
| rdValid | output | 1 | rdData holds a result this cycle |
| statusSet | input | 8 | Status bits to set, from the sequencer |
| cmdStrobe | output | 1 | One-cycle command pulse |
| cmdOpcode | output | 7 | Opcode of the last command |
| cmdDma | output | 1 | DMA flag of the last command |
| cmdLen | output | 6 | Command bytes collected |
| irq | output | 1 | Interrupt request level |

## Verification
A read issued on one clock edge returns its data, with rdValid high, right after that edge. The driver queues the expected byte when it issues the read. The monitor takes the byte from the queue on the falling edge that follows, while rdValid is high. cmdStrobe, cmdOpcode, cmdDma, cmdLen and irq all change on the same edge that takes the write or the statusSet pulse, so the driver checks them on the falling edge that ends that access. Side effects on registers are checked only by reads issued afterwards, which keeps each check apart from the edge that caused it.

// File: rtl/scsiRegPkg.sv
package scsiRegPkg;

  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_FIFO   = 2;
  localparam int IDX_CMD    = 3;
  localparam int IDX_STAT   = 4;
  localparam int IDX_INTR   = 5;
  localparam int IDX_SEQ    = 6;
  localparam int IDX_CFG    = 8;
  localparam int IDX_RO_A   = 9;
  localparam int IDX_CFG_MASKED = 11;
  localparam int IDX_OPEN_LO    = 12;
  localparam int IDX_REV    = 14;

  localparam logic [7:0] REV_ID       = 8'h04;
  localparam logic [7:0] MASK_CFG11   = 8'h15;
  localparam logic [7:0] STAT_TC      = 8'h10;
  localparam logic [7:0] STAT_ACKMASK = 8'hE0;
  localparam logic [7:0] INT_FUNC_DONE = 8'h08;
  localparam logic [7:0] INT_BUS_RST  = 8'h80;
  localparam int CFG_IRQ_OFF_BIT = 6;

  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_COLLECT  = 7'h43;

  typedef struct packed {
    logic regWr;
    logic regRd;
    logic countWr;
    logic fifoWr;
    logic fifoRd;
    logic intAck;
    logic dmaReload;
    logic flush;
    logic chipReset;
    logic busReset;
  } regStrobes_t;

endpackage

// File: rtl/scsiRegCtrl.sv
module scsiRegCtrl
  import scsiRegPkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CMD_DEPTH = 32,
  localparam int CMD_LEN_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic                 wrEn,
  input  logic [7:0]           wrData,
  input  logic                 rdEn,
  input  logic                 seqIrqReq,
  input  logic                 cfgIrqOff,
  output regStrobes_t          st,
  output logic                 cmdStrobe,
  output logic [6:0]           cmdOpcode,
  output logic                 cmdDma,
  output logic [CMD_LEN_W-1:0] cmdLen,
  output logic                 irq
);

  logic collecting;
  logic isCmd;
  logic cmdByteWr;
  logic doRd;
  logic [6:0] op;
  int ri;

  always_comb begin
    ri = int'(regIdx);
    op = wrData[6:0];
    doRd = rdEn && !wrEn;
    isCmd = wrEn && (ri == IDX_CMD);
    cmdByteWr = wrEn && (ri == IDX_FIFO) && collecting;
    st = '0;
    st.regWr     = wrEn;
    st.regRd     = doRd;
    st.countWr   = wrEn && (ri == IDX_CNT_LO || ri == IDX_CNT_HI);
    st.fifoWr    = wrEn && (ri == IDX_FIFO) && !collecting;
    st.fifoRd    = doRd && (ri == IDX_FIFO);
    st.intAck    = doRd && (ri == IDX_INTR);
    st.dmaReload = isCmd && wrData[7];
    st.flush     = isCmd && (op == OP_FLUSH);
    st.chipReset = isCmd && (op == OP_CHIP_RST);
    st.busReset  = isCmd && (op == OP_BUS_RST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStrobe <= 1'b0;
      cmdOpcode <= '0;
      cmdDma <= 1'b0;
    end else begin
      cmdStrobe <= isCmd;
      if (isCmd) begin
        cmdOpcode <= op;
        cmdDma <= wrData[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.chipReset) begin
      collecting <= 1'b0;
      cmdLen <= '0;
    end else if (isCmd && op == OP_COLLECT) begin
      collecting <= 1'b1;
      cmdLen <= '0;
    end else if (isCmd && op == OP_XFER) begin
      collecting <= 1'b0;
    end else if (cmdByteWr && cmdLen != CMD_LEN_W'(CMD_DEPTH)) begin
      cmdLen <= cmdLen + CMD_LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.chipReset) irq <= 1'b0;
    else if ((st.busReset && !cfgIrqOff) || seqIrqReq) irq <= 1'b1;
    else if (st.intAck) irq <= 1'b0;
  end

  AST_STROBE_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |=> (cmdStrobe && cmdOpcode == $past(wrData[6:0]) && cmdDma == $past(wrData[7]))); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !isCmd |=> !cmdStrobe); // R5
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (st.intAck && !seqIrqReq) |=> !irq); // R9
  AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (st.busReset && cfgIrqOff && !seqIrqReq && !irq) |=> !irq); // R8
  AST_CMDLEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    cmdLen <= CMD_LEN_W'(CMD_DEPTH)); // R12

endmodule

// File: rtl/scsiRegData.sv
module scsiRegData
  import scsiRegPkg::*;
#(
  parameter int IDX_W = 4,
  parameter int FIFO_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      st,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [7:0]       wrData,
  input  logic [7:0]       statusSet,
  output logic             cfgIrqOff,
  output logic [7:0]       rdData,
  output logic             rdValid
);

  localparam int NUM_REGS = 2 ** IDX_W;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [7:0] rdRegs [NUM_REGS];
  logic [7:0] wrRegs [NUM_REGS];
  logic [7:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] fifoCount;
  logic fifoFull, fifoHasData;
  logic [7:0] statusNext;
  int ri;

  assign ri = int'(regIdx);
  assign fifoFull = (fifoCount == CNT_W'(FIFO_DEPTH));
  assign fifoHasData = (fifoCount != '0);
  assign cfgIrqOff = wrRegs[IDX_CFG][CFG_IRQ_OFF_BIT];

  always_comb begin
    statusNext = rdRegs[IDX_STAT];
    if (st.countWr) statusNext = statusNext & ~STAT_TC;
    if (st.intAck) statusNext = statusNext & ~STAT_ACKMASK;
    statusNext = statusNext | statusSet;
  end

  always_ff @(posedge clk) begin
    if (st.fifoWr && !fifoFull) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.chipReset) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        rdRegs[i] <= '0;
        wrRegs[i] <= '0;
      end
      rdRegs[IDX_REV] <= REV_ID;
      rdPtr <= '0;
      wrPtr <= '0;
      fifoCount <= '0;
      rdData <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.regRd;
      rdRegs[IDX_STAT] <= statusNext;
      if (st.regRd)
        rdData <= (st.fifoRd && fifoHasData) ? fifoMem[rdPtr] : rdRegs[regIdx];
      if (st.regWr) begin
        wrRegs[regIdx] <= wrData;
        if (ri == IDX_CMD || ri == IDX_CFG || ri >= IDX_OPEN_LO)
          rdRegs[regIdx] <= wrData;
        else if (ri == IDX_CFG_MASKED)
          rdRegs[regIdx] <= wrData & MASK_CFG11;
      end
      if (st.dmaReload) begin
        rdRegs[IDX_CNT_LO] <= wrRegs[IDX_CNT_LO];
        rdRegs[IDX_CNT_HI] <= wrRegs[IDX_CNT_HI];
      end
      if (st.flush) begin
        rdRegs[IDX_INTR] <= INT_FUNC_DONE;
        rdRegs[IDX_SEQ] <= '0;
        rdPtr <= '0;
        wrPtr <= '0;
        fifoCount <= '0;
      end else if (st.busReset) begin
        rdRegs[IDX_INTR] <= INT_BUS_RST;
      end else if (st.fifoWr && !fifoFull) begin
        wrPtr <= wrPtr + PTR_W'(1);
        fifoCount <= fifoCount + CNT_W'(1);
      end else if (st.fifoRd && fifoHasData) begin
        rdRegs[IDX_FIFO] <= fifoMem[rdPtr];
        fifoCount <= fifoCount - CNT_W'(1);
        if (fifoCount == CNT_W'(1)) begin
          rdPtr <= '0;
          wrPtr <= '0;
        end else begin
          rdPtr <= rdPtr + PTR_W'(1);
        end
      end
    end
  end

  AST_TC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (st.countWr && !statusSet[4]) |=> !rdRegs[IDX_STAT][4]); // R3
  AST_REV_RESTORED: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.chipReset) |-> (rdRegs[IDX_REV] == REV_ID && fifoCount == '0)); // R7
  AST_READONLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (st.regWr && (ri == IDX_RO_A || ri == IDX_RO_A + 1)) |=> $stable(rdRegs[regIdx])); // R10
  AST_FIFO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (st.fifoWr && fifoFull) |=> fifoFull); // R11
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (statusSet != '0 && !st.chipReset) |=> ((rdRegs[IDX_STAT] & $past(statusSet)) == $past(statusSet))); // R13

endmodule

// File: rtl/scsiRegIf.sv
module scsiRegIf
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int FIFO_DEPTH = 32,
  parameter int CMD_DEPTH = 32,
  localparam int CMD_LEN_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 wrEn,
  input  logic [7:0]           wrData,
  input  logic                 rdEn,
  output logic [7:0]           rdData,
  output logic                 rdValid,
  input  logic [7:0]           statusSet,
  output logic                 cmdStrobe,
  output logic [6:0]           cmdOpcode,
  output logic                 cmdDma,
  output logic [CMD_LEN_W-1:0] cmdLen,
  output logic                 irq
);

  localparam int IDX_W = ADDR_W - 2;

  regStrobes_t strobes;
  logic [IDX_W-1:0] regIdx;
  logic cfgIrqOff;
  logic unusedAddrBits;

  assign regIdx = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = ^busAddr[1:0];

  scsiRegCtrl #(.IDX_W(IDX_W), .CMD_DEPTH(CMD_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .seqIrqReq(statusSet[7]), .cfgIrqOff(cfgIrqOff), .st(strobes),
    .cmdStrobe(cmdStrobe), .cmdOpcode(cmdOpcode), .cmdDma(cmdDma),
    .cmdLen(cmdLen), .irq(irq)
  );

  scsiRegData #(.IDX_W(IDX_W), .FIFO_DEPTH(FIFO_DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .st(strobes), .regIdx(regIdx), .wrData(wrData),
    .statusSet(statusSet), .cfgIrqOff(cfgIrqOff), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/scsiRegIf_tb.sv
`timescale 1ns/1ps
module scsiRegIf_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic rdValid;
  logic [7:0] statusSet = '0;
  logic cmdStrobe;
  logic [6:0] cmdOpcode;
  logic cmdDma;
  logic [5:0] cmdLen;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  scsiRegIf dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .statusSet(statusSet),
    .cmdStrobe(cmdStrobe), .cmdOpcode(cmdOpcode), .cmdDma(cmdDma),
    .cmdLen(cmdLen), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) begin
        chk(1, 0, "scoreboard: unexpected read result");
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(int'(rdData), int'(e), t);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseStatus(input logic [7:0] v);
    @(negedge clk);
    statusSet = v;
    @(negedge clk);
    statusSet = '0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, 1, "watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    chk(irq, 0, "R2 irq after reset");
    chk(cmdStrobe, 0, "R2 strobe after reset");
    chk(cmdLen, 0, "R2 cmdLen after reset");
    for (int i = 0; i < 16; i++)
      rd(6'(i * 4), (i == 14) ? 8'h04 : 8'h00, $sformatf("R2 reg%0d after reset", i));

    // R1 address decode
    wr(6'h30, 8'hA5);
    rd(6'h33, 8'hA5, "R1 low address bits ignored");
    rd(6'h31, 8'hA5, "R1 low address bits ignored 2");

    // R10 write masks and read-only registers
    wr(6'h2C, 8'hFF);  rd(6'h2C, 8'h15, "R10 reg11 mask");
    wr(6'h20, 8'h3C);  rd(6'h20, 8'h3C, "R10 reg8 stored");
    wr(6'h3C, 8'h77);  rd(6'h3C, 8'h77, "R10 reg15 stored");
    wr(6'h24, 8'hAA);  rd(6'h24, 8'h00, "R10 reg9 read-only");
    wr(6'h18, 8'h55);  rd(6'h18, 8'h00, "R10 reg6 read-only");
    wr(6'h1C, 8'h11);  rd(6'h1C, 8'h00, "R10 reg7 read-only");

    // R5 command strobe
    wr(6'h0C, 8'h05);
    chk(cmdStrobe, 1, "R5 strobe high");
    chk(cmdOpcode, 8'h05, "R5 opcode");
    chk(cmdDma, 0, "R5 dma flag clear");
    @(negedge clk);
    chk(cmdStrobe, 0, "R5 strobe one cycle");
    rd(6'h0C, 8'h05, "R10 reg3 holds command");

    // R4 DMA reload
    wr(6'h00, 8'h12);
    wr(6'h00, 8'h34);
    wr(6'h04, 8'h56);
    rd(6'h00, 8'h00, "R4 count not loaded by write");
    wr(6'h0C, 8'h00);
    rd(6'h00, 8'h00, "R4 no reload without dma bit");
    wr(6'h0C, 8'h80);
    chk(cmdDma, 1, "R5 dma flag set");
    chk(cmdOpcode, 0, "R5 opcode with dma");
    rd(6'h00, 8'h34, "R4 reload low byte");
    rd(6'h04, 8'h56, "R4 reload high byte");

    // R13, R3, R9 status handling
    pulseStatus(8'h10);
    chk(irq, 0, "R13 no irq without bit7");
    rd(6'h10, 8'h10, "R13 status bit set");
    wr(6'h00, 8'h01);
    rd(6'h10, 8'h00, "R3 terminal count cleared");
    pulseStatus(8'hF3);
    chk(irq, 1, "R13 bit7 raises irq");
    rd(6'h10, 8'hF3, "R13 status OR");
    rd(6'h14, 8'h00, "R9 interrupt reg value");
    chk(irq, 0, "R9 read drops irq");
    rd(6'h10, 8'h13, "R9 status bits cleared");

    // R8 bus reset
    wr(6'h0C, 8'h03);
    chk(irq, 1, "R8 irq when reg8 bit6 clear");
    rd(6'h14, 8'h80, "R8 interrupt code");
    chk(irq, 0, "R9 ack after bus reset");
    wr(6'h20, 8'h40);
    wr(6'h0C, 8'h03);
    chk(irq, 0, "R8 irq masked by reg8 bit6");
    rd(6'h14, 8'h80, "R8 interrupt code masked case");

    // R11 FIFO
    wr(6'h08, 8'h11); wr(6'h08, 8'h22); wr(6'h08, 8'h33);
    rd(6'h08, 8'h11, "R11 fifo order 0");
    rd(6'h08, 8'h22, "R11 fifo order 1");
    rd(6'h08, 8'h33, "R11 fifo order 2");
    rd(6'h08, 8'h33, "R11 empty read repeats last");
    for (int i = 0; i < 34; i++) wr(6'h08, 8'(8'h40 + i));
    for (int i = 0; i < 32; i++) rd(6'h08, 8'(8'h40 + i), $sformatf("R11 full fifo byte %0d", i));
    rd(6'h08, 8'h5F, "R11 bytes past 32 dropped");
    wr(6'h08, 8'h99);
    rd(6'h08, 8'h99, "R11 refill after empty");

    // R6 flush
    wr(6'h08, 8'hA1); wr(6'h08, 8'hA2);
    wr(6'h0C, 8'h01);
    rd(6'h14, 8'h08, "R6 function complete");
    rd(6'h18, 8'h00, "R6 sequence step");
    rd(6'h08, 8'h99, "R6 buffer emptied");

    // R12 command collection
    wr(6'h0C, 8'h43);
    chk(cmdOpcode, 8'h43, "R12 collect opcode");
    chk(cmdLen, 0, "R12 count cleared");
    wr(6'h08, 8'h01); wr(6'h08, 8'h02); wr(6'h08, 8'h03);
    chk(cmdLen, 3, "R12 command bytes counted");
    rd(6'h08, 8'h99, "R12 data buffer untouched");
    wr(6'h0C, 8'h10);
    wr(6'h08, 8'h5A);
    chk(cmdLen, 3, "R12 window closed");
    rd(6'h08, 8'h5A, "R12 data buffer after close");

    // R7 chip reset
    wr(6'h38, 8'h09);
    rd(6'h38, 8'h09, "R10 reg14 stored");
    wr(6'h08, 8'h66);
    wr(6'h0C, 8'h43);
    wr(6'h08, 8'h07);
    pulseStatus(8'h80);
    chk(irq, 1, "R13 irq before chip reset");
    wr(6'h0C, 8'h02);
    chk(irq, 0, "R7 irq cleared");
    chk(cmdLen, 0, "R7 cmdLen cleared");
    for (int i = 0; i < 16; i++)
      rd(6'(i * 4), (i == 14) ? 8'h04 : 8'h00, $sformatf("R7 reg%0d after chip reset", i));
    wr(6'h0C, 8'h80);
    rd(6'h00, 8'h00, "R7 write copies cleared");
    wr(6'h08, 8'h3E);
    rd(6'h08, 8'h3E, "R7 collection closed");

    repeat (2) @(negedge clk);
    chk(expQ.size(), 0, "scoreboard drained");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule